// File: doc/BRIEF.md
# I2C EEPROM Target Emulator

This block is a synthesizable I2C target that answers on a two-wire bus as a byte-wide serial EEPROM would. The bus clock and data lines enter as plain inputs and pass through two-flop synchronisers. The block drives the data line only through a pull-low enable, so the outside wiring can build a true open-drain line. Behind the bus engine sits a byte memory written so that block RAM can be inferred. A 64-byte page buffer sits in front of it.

A host selects the target with a control byte. The host then sends a two-byte word address and either streams data bytes to write or reads back. A random read is a dummy write of the address, followed by a repeated START and a read control byte. Written bytes stay in the page buffer until STOP. They are then copied into the array during a modelled self-timed write cycle whose length is a parameter in system clock cycles. While that cycle runs, the target ignores its own address, so the host can poll for completion. A write-protect input discards writes while still acknowledging them.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A control byte is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal `strap_i` (bit 0 = 1 selects read). Any other control byte is not acknowledged, and the target stays silent until the next START.
- R2: `sda_pull_o` is 0 after reset and changes only while the synchronised SCL is low.
- R3: A single data byte written to an address and then fetched by a random read (address write, repeated START, read control byte) returns the written value. The address-only write of a random read starts no write cycle.
- R4: A write of up to PAGE_BYTES data bytes has every byte acknowledged, and all the bytes become readable after STOP.
- R5: Data bytes beyond the end of a page wrap to the start of the same page. Later bytes overwrite earlier ones, and neighbouring pages are unchanged.
- R6: After a STOP that ends a write with at least one data byte, the control byte is not acknowledged for WR_CYCLES clock cycles and is acknowledged again afterwards.
- R7: While `wp_i` is 1 at STOP, a write has all its bytes acknowledged but changes no location, and no write cycle starts.
- R8: In a read, the address advances by one after each byte the host acknowledges, and wraps from the top address to 0.
- R9: When the host does not acknowledge a read byte, the target releases the data line for the rest of the transaction.
- R10: Data bytes of a write that ends in a repeated START rather than STOP are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (as seen on the wire) |
| strap_i | input | 3 | Address strap bits compared with control byte bits 3..1 |
| wp_i | input | 1 | Write protect, 1 = writes discarded |
| sda_pull_o | output | 1 | 1 = pull the data line low |

## Verification
The hardest state to reach from the ports is the write cycle itself. It only exists after a STOP that follows real data bytes, and it can only be seen as a missing acknowledge. The bench therefore polls with a control byte straight after every write STOP. It requires the first poll to be refused and checks that the acknowledge comes no earlier than the programmed cycle count. Page wrap and top-of-array wrap are reached by a full fill of a small array, followed by a read of every address plus two wrapped bytes.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } eep_state_t;

  localparam logic [3:0] CTRL_PREFIX = 4'b1010;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= {(STAGES+1){RST_VAL}};
    else     pipe_q <= {pipe_q[STAGES-1:0], d_i};
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] arr [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we_i) arr[waddr_i] <= wdata_i;
    rdata_o <= arr[raddr_i];
  end
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eep_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 64,
  parameter int WR_CYCLES  = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_pull_o
);
  localparam int PG_W   = $clog2(PAGE_BYTES);
  localparam int BUSY_W = $clog2(WR_CYCLES + 1);

  initial assert_cfg_R4: assert (WR_CYCLES >= PAGE_BYTES && ADDR_W > PG_W && ADDR_W <= 16
                                 && (1 << PG_W) == PAGE_BYTES)
    else $error("bad configuration");

  // line synchronisers: index 0 = SCL, index 1 = SDA
  logic [1:0] raw, lvl, rise, fall;
  assign raw = {sda_i, scl_i};
  for (genvar g = 0; g < 2; g++) begin : g_sync
    eep_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
      .clk(clk), .rst(rst), .d_i(raw[g]),
      .lvl_o(lvl[g]), .rise_o(rise[g]), .fall_o(fall[g])
    );
  end

  logic scl_lvl, scl_rise, scl_fall, sda_lvl, start_ev, stop_ev;
  assign scl_lvl  = lvl[0];
  assign scl_rise = rise[0];
  assign scl_fall = fall[0];
  assign sda_lvl  = lvl[1];
  assign start_ev = scl_lvl & fall[1];
  assign stop_ev  = scl_lvl & rise[1];

  eep_state_t             st;
  logic [3:0]             bcnt;
  logic [7:0]             sh;
  logic [7:0]             ahi;
  logic [ADDR_W-1:0]      ptr;
  logic                   pull_q;
  logic [PAGE_BYTES-1:0]  mask, cm_mask;
  logic [BUSY_W-1:0]      busy_cnt;
  logic                   cm_act;
  logic [PG_W-1:0]        cm_idx;
  logic [ADDR_W-1:PG_W]   cm_page;
  logic [7:0]             pbuf [0:PAGE_BYTES-1];
  logic [7:0]             mem_q;
  logic                   busy, byte_done, ctrl_hit, mem_we;

  assign busy      = (busy_cnt != '0);
  assign byte_done = scl_fall && (bcnt == 4'd8) && (st inside {ST_CTRL, ST_AHI, ST_ALO, ST_WR});
  assign ctrl_hit  = (sh[7:4] == CTRL_PREFIX) && (sh[3:1] == strap_i) && !busy;
  assign mem_we    = cm_act && cm_mask[cm_idx];

  // page buffer: plain storage, no reset
  always_ff @(posedge clk) begin
    if (byte_done && st == ST_WR) pbuf[ptr[PG_W-1:0]] <= sh;
  end

  eep_mem #(.AW(ADDR_W), .DW(8)) mem_i (
    .clk(clk), .we_i(mem_we), .waddr_i({cm_page, cm_idx}), .wdata_i(pbuf[cm_idx]),
    .raddr_i(ptr), .rdata_o(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bcnt     <= '0;
      sh       <= '0;
      ahi      <= '0;
      ptr      <= '0;
      pull_q   <= 1'b0;
      mask     <= '0;
      cm_mask  <= '0;
      busy_cnt <= '0;
      cm_act   <= 1'b0;
      cm_idx   <= '0;
      cm_page  <= '0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - BUSY_W'(1);
      if (cm_act) begin
        cm_idx <= cm_idx + PG_W'(1);
        if (cm_idx == PG_W'(PAGE_BYTES - 1)) cm_act <= 1'b0;
      end

      if (start_ev) begin
        st     <= ST_CTRL;
        bcnt   <= '0;
        pull_q <= 1'b0;
        mask   <= '0;
      end else if (stop_ev) begin
        st     <= ST_IDLE;
        pull_q <= 1'b0;
        mask   <= '0;
        if (st == ST_WR && |mask && !wp_i) begin
          cm_mask  <= mask;
          cm_act   <= 1'b1;
          cm_idx   <= '0;
          cm_page  <= ptr[ADDR_W-1:PG_W];
          busy_cnt <= BUSY_W'(WR_CYCLES);
        end
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (st == ST_RD) begin
            if (bcnt == 4'd8) begin
              if (!sda_lvl) begin
                ptr  <= ptr + ADDR_W'(1);
                bcnt <= 4'd9;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              bcnt <= bcnt + 4'd1;
            end
          end else if (bcnt < 4'd8) begin
            sh   <= {sh[6:0], sda_lvl};
            bcnt <= bcnt + 4'd1;
          end
        end else if (scl_fall) begin
          if (st == ST_RD) begin
            if (bcnt == 4'd9) begin
              bcnt   <= '0;
              pull_q <= ~mem_q[7];
            end else if (bcnt == 4'd8) begin
              pull_q <= 1'b0;
            end else begin
              pull_q <= ~mem_q[~bcnt[2:0]];
            end
          end else if (bcnt == 4'd8) begin
            bcnt <= 4'd9;
            case (st)
              ST_CTRL: begin
                if (ctrl_hit) pull_q <= 1'b1;
                else          st     <= ST_IDLE;
              end
              ST_AHI: begin
                ahi    <= sh;
                pull_q <= 1'b1;
              end
              ST_ALO: begin
                ptr    <= ADDR_W'({ahi, sh});
                mask   <= '0;
                pull_q <= 1'b1;
              end
              default: begin
                mask[ptr[PG_W-1:0]] <= 1'b1;
                ptr[PG_W-1:0]       <= ptr[PG_W-1:0] + PG_W'(1);
                pull_q              <= 1'b1;
              end
            endcase
          end else if (bcnt == 4'd9) begin
            bcnt   <= '0;
            pull_q <= 1'b0;
            case (st)
              ST_CTRL: begin
                if (sh[0]) begin
                  st     <= ST_RD;
                  pull_q <= ~mem_q[7];
                end else begin
                  st <= ST_AHI;
                end
              end
              ST_AHI:  st <= ST_ALO;
              ST_ALO:  st <= ST_WR;
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign sda_pull_o = pull_q;

  assert_pull_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(pull_q) |-> !scl_lvl)
    else $error("data line changed while SCL high");

  assert_busy_nack_R6: assert property (@(posedge clk) disable iff (rst)
    (byte_done && st == ST_CTRL && busy) |=> !pull_q)
    else $error("control byte acknowledged during write cycle");

  assert_commit_in_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    cm_act |-> busy)
    else $error("array written outside write cycle");

  assert_wp_discard_R7: assert property (@(posedge clk) disable iff (rst)
    (stop_ev && wp_i && !cm_act) |=> !cm_act)
    else $error("protected write committed");

  assert_page_stay_R5: assert property (@(posedge clk) disable iff (rst)
    (byte_done && st == ST_WR) |=> $stable(ptr[ADDR_W-1:PG_W]))
    else $error("write pointer left its page");

  assert_read_step_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD && scl_rise && bcnt == 4'd8 && !sda_lvl && !start_ev && !stop_ev)
      |=> ptr == ADDR_W'($past(ptr) + ADDR_W'(1)))
    else $error("read pointer did not advance by one");
endmodule

// File: tb/i2c_eeprom_target_tb_top.sv
module i2c_eeprom_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 8;
  localparam int PG   = 16;
  localparam int WRC  = 200;
  localparam int H    = 5;
  localparam int SIZE = 1 << AW;
  localparam logic [7:0] CW = 8'hAA;  // 1010_101_0
  localparam logic [7:0] CR = 8'hAB;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_h = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_pull, sda_line;
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;
  logic [7:0] model [0:SIZE-1];

  assign sda_line = sda_h & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_eeprom_target #(.ADDR_W(AW), .PAGE_BYTES(PG), .WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .wp_i(wp), .sda_pull_o(sda_pull)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_h = 1'b1; wt(H); scl = 1'b1; wt(H); sda_h = 1'b0; wt(H); scl = 1'b0; wt(H);
  endtask

  task automatic i2c_stop;
    sda_h = 1'b0; wt(H); scl = 1'b1; wt(H); sda_h = 1'b1; wt(H);
  endtask

  task automatic put_bit(bit b);
    sda_h = b; wt(H); scl = 1'b1; wt(H); scl = 1'b0; wt(H);
  endtask

  task automatic get_bit(output bit b);
    sda_h = 1'b1; wt(H); scl = 1'b1; wt(2); b = sda_line; wt(H-2); scl = 1'b0; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(!ack);
  endtask

  // address write, repeated START, read control byte
  task automatic rd_open(input logic [7:0] addr);
    bit a0, a1, a2, a3;
    i2c_start; send_byte(CW, a0); send_byte(8'h00, a1); send_byte(addr, a2);
    i2c_start; send_byte(CR, a3);
    chk(a0 && a1 && a2 && a3, "R3 random read header acked", {a0, a1, a2, a3}, 4'hF);
  endtask

  task automatic read_one(input logic [7:0] addr, output logic [7:0] v);
    rd_open(addr);
    recv_byte(v, 1'b0);
    i2c_stop;
  endtask

  task automatic wait_ready(input int t0, input bit expect_busy);
    bit ack = 1'b0;
    for (int k = 0; k < 10; k++) begin
      i2c_start; send_byte(CW, ack); i2c_stop;
      if (k == 0) chk(ack == !expect_busy, "R6 first poll after STOP", ack, !expect_busy);
      if (ack) break;
    end
    chk(ack, "R6 acknowledged after write cycle", ack, 1);
    if (expect_busy) chk(cyc - t0 >= WRC - H, "R6 busy window length", cyc - t0, WRC);
  endtask

  task automatic write_bytes(input int addr, input int n, input int seed, input bit upd);
    bit ack, all;
    all = 1'b1;
    i2c_start; send_byte(CW, ack); all &= ack;
    send_byte(8'h00, ack); all &= ack;
    send_byte(8'(addr), ack); all &= ack;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'((seed < 0) ? pat(addr + i) : ((i * 29 + seed) & 255));
      send_byte(d, ack); all &= ack;
      if (upd) model[(addr & ~(PG-1)) | ((addr + i) & (PG-1))] = d;
    end
    chk(all, "R4 every write byte acked", all, 1);
    i2c_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack, b;
    logic [7:0] v;
    int t0;
    wt(4);
    chk(sda_pull == 1'b0, "R2 released in reset", sda_pull, 0);
    rst = 1'b0;
    wt(4);
    chk(sda_pull == 1'b0, "R2 released after reset", sda_pull, 0);

    // R1: sweep strap field, plus a wrong prefix
    for (int s = 0; s < 8; s++) begin
      i2c_start; send_byte({4'b1010, 3'(s), 1'b0}, ack); i2c_stop;
      chk(ack == (s == 5), "R1 strap match decides ACK", ack, s == 5);
    end
    for (int p = 0; p < 16; p++) begin
      i2c_start; send_byte({4'(p), 3'b101, 1'b0}, ack); i2c_stop;
      chk(ack == (p == 10), "R1 prefix 1010 decides ACK", ack, p == 10);
    end

    // R4/R6: fill every page, poll after each
    for (int pg = 0; pg < SIZE / PG; pg++) begin
      write_bytes(pg * PG, PG, -1, 1'b1);
      t0 = cyc;
      wait_ready(t0, 1'b1);
    end

    // R8: read whole array plus two wrapped bytes
    rd_open(8'h00);
    for (int i = 0; i < SIZE + 2; i++) begin
      recv_byte(v, i != SIZE + 1);
      chk(v == model[i % SIZE], "R8 sequential read with wrap (R4 data)", v, model[i % SIZE]);
    end
    get_bit(b);
    chk(b == 1'b1, "R9 line released after host NACK", b, 1);
    i2c_stop;

    // R3: single byte write, random read, no cycle from dummy write
    write_bytes(8'h5A, 1, 8'hC3, 1'b1);
    t0 = cyc;
    wait_ready(t0, 1'b1);
    read_one(8'h5A, v);
    chk(v == 8'hC3, "R3 single byte readback", v, 8'hC3);
    i2c_start; send_byte(CW, ack); i2c_stop;
    chk(ack, "R3 dummy write starts no cycle", ack, 1);

    // R5: page wrap, 20 bytes from offset 12 of page 2
    write_bytes(8'h2C, PG + 4, 8'h41, 1'b1);
    t0 = cyc;
    wait_ready(t0, 1'b1);
    rd_open(8'h1F);
    for (int i = 0; i < 18; i++) begin
      recv_byte(v, i != 17);
      chk(v == model[8'h1F + i], "R5 page wrap contents", v, model[8'h1F + i]);
    end
    i2c_stop;

    // R7: write protect
    wp = 1'b1;
    write_bytes(8'h80, 3, 8'h11, 1'b0);
    wait_ready(cyc, 1'b0);
    wp = 1'b0;
    rd_open(8'h80);
    for (int i = 0; i < 3; i++) begin
      recv_byte(v, i != 2);
      chk(v == model[8'h80 + i], "R7 protected write discarded", v, model[8'h80 + i]);
    end
    i2c_stop;

    // R10: data then repeated START is discarded
    i2c_start; send_byte(CW, ack); send_byte(8'h00, ack); send_byte(8'h90, ack);
    send_byte(8'h55, ack);
    i2c_start; send_byte(CW, ack); send_byte(8'h00, ack); send_byte(8'h90, ack);
    i2c_start; send_byte(CR, ack);
    recv_byte(v, 1'b0);
    i2c_stop;
    chk(v == model[8'h90], "R10 repeated START drops data", v, model[8'h90]);
    i2c_start; send_byte(CW, ack); i2c_stop;
    chk(ack, "R10 no write cycle started", ack, 1);
    read_one(8'h90, v);
    chk(v == model[8'h90], "R10 location unchanged", v, model[8'h90]);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule